// File: doc/BRIEF.md
# Spanning-Tree Port Forwarding Gate

This block filters frames by port state for a five-port Ethernet switch. Port index 4 is the host-processor port. Indices 0 to 3 are the network ports, and each of them holds three configuration bits: transmit enable, receive enable and learning disable. The forwarding engine presents one frame event per handshake. An event carries the ingress port index, the candidate destination mask, and the result of a static-table lookup (a hit flag and the override flag of the entry that hit). The gate returns the egress mask after filtering by spanning-tree state, together with a strobe that permits source-address learning.

Normal traffic passes only where the ingress port receives and the egress port transmits. Two paths bypass these state bits. A frame that hits a static entry with the override flag set always reaches the host port, so protocol frames still reach software while a port is blocked. A frame sourced by the host may egress any port it names, whatever that port's state. Configuration is written through a plain write port. A write takes effect for events accepted in later cycles.

Both frame interfaces use valid/ready. An event is accepted on a clock edge where `ev_valid` and `ev_ready` are both high. Its decision appears on `dec_valid` in the next cycle. The decision stays unchanged until the cycle in which `dec_ready` is high. The input accepts a new event whenever the output register is empty or is being drained in that same cycle, so a stalled consumer stalls the producer without losing any event.

Top module: `stp_port_gate`

## Requirements
- R1: After reset, `dec_valid` is 0, `ev_ready` is 1, and every network port holds the discarding code (tx=0, rx=0, learn_dis=1). As a result, a frame from a network port yields a mask of 0 and no learn permit.
- R2: `cfg_data` is packed as bit 2 = transmit enable, bit 1 = receive enable, bit 0 = learning disable. A write to a network port index updates that port. A write to index 4 or higher is ignored, and the host port stays at tx=1, rx=1, learn_dis=0. An event accepted in the same cycle as a write still sees the old setting.
- R3: When an event's ingress is a network port with receive enable 0, and the event is not an override hit, the result is an empty egress mask.
- R4: When an event's ingress is a network port and `ev_hit` and `ev_ovr` are both 1, host bit 4 is set in the result whatever the port states and `ev_dst` are. If the ingress port's receive enable is 0, that bit is the only one set.
- R5: When an event's ingress is a network port with receive enable 1, egress bit i is set exactly when `ev_dst[i]` is 1 and port i transmits. The host port always counts as transmitting. Host bit 4 is also added on an override hit.
- R6: When an event's ingress is the host port, the egress mask equals `ev_dst` with the host bit cleared, regardless of any port's transmit enable.
- R7: `dec_learn` equals the inverse of the ingress port's learning-disable bit. It is therefore 1 for host ingress, and 1 in the learning (0,0,0) and forwarding (1,1,0) states.
- R8: The ingress port's own bit is always 0 in the egress mask.
- R9: An ingress index of 5 or above yields mask 0 and `dec_learn` 0.
- R10: `ev_ready` equals `!dec_valid || dec_ready`. An accepted event produces `dec_valid` in the next cycle. While `dec_valid` is high and `dec_ready` is low, the mask and learn outputs hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | 3 | Port index written |
| cfg_data | input | 3 | {tx_en, rx_en, learn_dis} |
| ev_valid | input | 1 | Frame event valid |
| ev_ready | output | 1 | Gate can accept an event |
| ev_src | input | 3 | Ingress port index |
| ev_dst | input | 5 | Candidate destination mask, bit i = port i |
| ev_hit | input | 1 | Static-table lookup hit |
| ev_ovr | input | 1 | Override flag of the hit entry |
| dec_valid | output | 1 | Decision valid |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_mask | output | 5 | Filtered egress mask |
| dec_learn | output | 1 | Source-address learning permitted |

## Verification
Every network port is swept through all five spanning-tree states while the other ports hold differing states. Normal, override-hit, hit-without-override and host-sourced frames are sent in each state. A gate that let blocked ingress leak to network ports, or that dropped the host bit on an override hit, would show a wrong mask. So would a gate that applied transmit enable to host-sourced frames. A gate that leaves the ingress bit set would put the frame back out on the port it arrived from. Configuration written in the same cycle as an event must not apply to that event, and writes aimed at the host port must not silence it. Random back-pressure on `dec_ready` exposes any decision that changes or is lost while stalled.

// File: rtl/stp_gate_pkg.sv
package stp_gate_pkg;
  // Per-port configuration word: {tx_en, rx_en, learn_dis}
  typedef struct packed {
    logic tx_en;
    logic rx_en;
    logic learn_dis;
  } port_cfg_t;

  localparam port_cfg_t CFG_DISCARD = '{tx_en: 1'b0, rx_en: 1'b0, learn_dis: 1'b1};
  localparam port_cfg_t CFG_LEARN   = '{tx_en: 1'b0, rx_en: 1'b0, learn_dis: 1'b0};
  localparam port_cfg_t CFG_FORWARD = '{tx_en: 1'b1, rx_en: 1'b1, learn_dis: 1'b0};
endpackage

// File: rtl/stp_cfg_regs.sv
module stp_cfg_regs
  import stp_gate_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_port,
  input  logic [2:0]           cfg_data,
  output logic [NUM_PORTS-1:0] tx_vec,
  output logic [NUM_PORTS-1:0] rx_vec,
  output logic [NUM_PORTS-1:0] ldis_vec
);
  localparam int HOST = NUM_PORTS - 1;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    if (i == HOST) begin : g_host
      // the host port is never gated
      assign tx_vec[i]   = 1'b1;
      assign rx_vec[i]   = 1'b1;
      assign ldis_vec[i] = 1'b0;
    end else begin : g_net
      port_cfg_t cfg_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          cfg_q <= CFG_DISCARD;
        else if (cfg_we && cfg_port == IDX_W'(i))
          cfg_q <= port_cfg_t'(cfg_data);
      end
      assign tx_vec[i]   = cfg_q.tx_en;
      assign rx_vec[i]   = cfg_q.rx_en;
      assign ldis_vec[i] = cfg_q.learn_dis;
    end
  end
endmodule

// File: rtl/stp_gate_logic.sv
module stp_gate_logic #(
  parameter int NUM_PORTS = 5,
  parameter int IDX_W     = 3
) (
  input  logic [IDX_W-1:0]     src,
  input  logic [NUM_PORTS-1:0] dst,
  input  logic                 hit,
  input  logic                 ovr,
  input  logic [NUM_PORTS-1:0] tx_vec,
  input  logic [NUM_PORTS-1:0] rx_vec,
  input  logic [NUM_PORTS-1:0] ldis_vec,
  output logic [NUM_PORTS-1:0] mask,
  output logic                 learn
);
  localparam int HOST = NUM_PORTS - 1;

  logic [NUM_PORTS-1:0] src_oh;
  logic                 src_ok;
  logic                 from_host;
  logic                 rx_src;
  logic                 ovr_hit;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_dec
    assign src_oh[i] = (src == IDX_W'(i));
  end

  assign src_ok    = |src_oh;
  assign from_host = src_oh[HOST];
  assign rx_src    = |(src_oh & rx_vec);
  assign ovr_hit   = hit & ovr;
  assign learn     = src_ok & ~(|(src_oh & ldis_vec));

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_egr
    logic normal_ok;
    logic bypass_ok;
    assign normal_ok = rx_src & dst[i] & tx_vec[i];
    if (i == HOST) begin : g_hbit
      assign bypass_ok = from_host ? 1'b0 : ovr_hit;
    end else begin : g_nbit
      assign bypass_ok = from_host & dst[i];
    end
    assign mask[i] = src_ok & ~src_oh[i] & (normal_ok | bypass_ok);
  end
endmodule

// File: rtl/stp_out_stage.sv
module stp_out_stage #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = ~vld_q | out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end
endmodule

// File: rtl/stp_port_gate.sv
module stp_port_gate #(
  parameter int NUM_PORTS = 5,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_port,
  input  logic [2:0]           cfg_data,
  input  logic                 ev_valid,
  output logic                 ev_ready,
  input  logic [IDX_W-1:0]     ev_src,
  input  logic [NUM_PORTS-1:0] ev_dst,
  input  logic                 ev_hit,
  input  logic                 ev_ovr,
  output logic                 dec_valid,
  input  logic                 dec_ready,
  output logic [NUM_PORTS-1:0] dec_mask,
  output logic                 dec_learn
);
  localparam int DW = NUM_PORTS + 1;

  logic [NUM_PORTS-1:0] tx_vec, rx_vec, ldis_vec;
  logic [NUM_PORTS-1:0] nxt_mask;
  logic                 nxt_learn;
  logic [DW-1:0]        out_word;

  stp_cfg_regs #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
    .cfg_data(cfg_data), .tx_vec(tx_vec), .rx_vec(rx_vec), .ldis_vec(ldis_vec)
  );

  stp_gate_logic #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_logic (
    .src(ev_src), .dst(ev_dst), .hit(ev_hit), .ovr(ev_ovr),
    .tx_vec(tx_vec), .rx_vec(rx_vec), .ldis_vec(ldis_vec),
    .mask(nxt_mask), .learn(nxt_learn)
  );

  stp_out_stage #(.W(DW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ev_valid), .in_ready(ev_ready), .in_data({nxt_learn, nxt_mask}),
    .out_valid(dec_valid), .out_ready(dec_ready), .out_data(out_word)
  );

  assign dec_mask  = out_word[NUM_PORTS-1:0];
  assign dec_learn = out_word[NUM_PORTS];
endmodule

// File: rtl/stp_port_gate_chk.sv
module stp_port_gate_chk #(
  parameter int NUM_PORTS = 5,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ev_valid,
  input logic                 ev_ready,
  input logic [IDX_W-1:0]     ev_src,
  input logic                 ev_hit,
  input logic                 ev_ovr,
  input logic                 dec_valid,
  input logic                 dec_ready,
  input logic [NUM_PORTS-1:0] dec_mask,
  input logic                 dec_learn,
  input logic [NUM_PORTS-1:0] rx_vec,
  input logic [NUM_PORTS-1:0] ldis_vec
);
  localparam int HOST = NUM_PORTS - 1;
  localparam logic [IDX_W-1:0] HOST_IDX = IDX_W'(HOST);

  logic acc;
  assign acc = ev_valid & ev_ready;

  a_r10_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> dec_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_mask) && $stable(dec_learn)));

  a_r10_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |-> !ev_ready);

  a_r9_bad_src: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ev_src > HOST_IDX) |=> (dec_mask == '0 && !dec_learn));

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_p
    a_r8_no_hairpin: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ev_src == IDX_W'(i)) |=> !dec_mask[i]);

    a_r7_learn: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ev_src == IDX_W'(i)) |=> (dec_learn == !$past(ldis_vec[i])));

    if (i != HOST) begin : g_net
      a_r3_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ev_src == IDX_W'(i) && !rx_vec[i] && !(ev_hit && ev_ovr)) |=> (dec_mask == '0));

      a_r4_override: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ev_src == IDX_W'(i) && ev_hit && ev_ovr) |=> dec_mask[HOST]);
    end
  end
endmodule

bind stp_port_gate stp_port_gate_chk #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_src(ev_src), .ev_hit(ev_hit), .ev_ovr(ev_ovr),
  .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_mask(dec_mask),
  .dec_learn(dec_learn), .rx_vec(rx_vec), .ldis_vec(ldis_vec)
);

// File: tb/stp_port_gate_bench.sv
`timescale 1ns/1ps
module stp_port_gate_bench;
  localparam int NP   = 5;
  localparam int IW   = 3;
  localparam int HOST = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          cfg_we;
  logic [IW-1:0] cfg_port;
  logic [2:0]    cfg_data;
  logic          ev_valid, ev_ready;
  logic [IW-1:0] ev_src;
  logic [NP-1:0] ev_dst;
  logic          ev_hit, ev_ovr;
  logic          dec_valid, dec_ready;
  logic [NP-1:0] dec_mask;
  logic          dec_learn;

  stp_port_gate u_stp_port_gate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_data(cfg_data),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_src(ev_src), .ev_dst(ev_dst),
    .ev_hit(ev_hit), .ev_ovr(ev_ovr), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_mask(dec_mask), .dec_learn(dec_learn)
  );

  // state codes {tx, rx, learn_dis}
  localparam logic [2:0] S_DIS = 3'b001, S_BLK = 3'b001, S_LSN = 3'b001,
                         S_LRN = 3'b000, S_FWD = 3'b110;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [2:0] m_cfg [NP];
  int q_mask[$], q_learn[$], q_src[$];
  string q_tag[$];
  string cur_tag;
  logic [7:0] lfsr = 8'hA5;
  bit last_acc;
  bit hold_prev = 0;
  logic [NP-1:0] hold_mask;
  logic hold_learn;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input int src, input logic [NP-1:0] dst, input logic hit,
                                input logic ovr, output int mask, output int learn);
    mask = 0; learn = 0;
    if (src >= NP) return;
    if (src == HOST) begin
      mask = int'(dst) & ~(1 << HOST);
      learn = 1;
      return;
    end
    if (m_cfg[src][1]) begin
      for (int i = 0; i < NP; i++)
        if (dst[i] && (i == HOST || m_cfg[i][2])) mask |= (1 << i);
    end
    if (hit && ovr) mask |= (1 << HOST);
    mask &= ~(1 << src);
    learn = m_cfg[src][0] ? 0 : 1;
  endfunction

  task automatic step();
    int em, el, es;
    string et;
    #1;
    chk(ev_ready == (!dec_valid || dec_ready), "R10 ready rule", ev_ready, !dec_valid || dec_ready);
    if (hold_prev) begin
      chk(dec_valid && dec_mask == hold_mask && dec_learn == hold_learn,
          "R10 stall hold", {dec_valid, dec_learn, dec_mask}, {1'b1, hold_learn, hold_mask});
    end
    hold_prev = dec_valid && !dec_ready;
    hold_mask = dec_mask; hold_learn = dec_learn;
    if (dec_valid && dec_ready) begin
      if (q_mask.size() == 0) chk(0, "R10 unexpected output", 1, 0);
      else begin
        em = q_mask.pop_front(); el = q_learn.pop_front();
        es = q_src.pop_front(); et = q_tag.pop_front();
        chk(int'(dec_mask) == em, {et, " mask"}, dec_mask, em);
        chk(int'(dec_learn) == el, {et, " R7 learn"}, dec_learn, el);
        if (es < NP) chk(!dec_mask[es], "R8 ingress bit", dec_mask, em);
      end
    end
    last_acc = ev_valid && ev_ready;
    if (last_acc) begin
      model(int'(ev_src), ev_dst, ev_hit, ev_ovr, em, el);
      q_mask.push_back(em); q_learn.push_back(el);
      q_src.push_back(int'(ev_src)); q_tag.push_back(cur_tag);
    end
    if (cfg_we && int'(cfg_port) < HOST) m_cfg[cfg_port] = cfg_data;
    @(negedge clk);
    cfg_we = 1'b0;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    dec_ready = lfsr[0] | lfsr[1];
  endtask

  task automatic wr(input int p, input logic [2:0] d);
    cfg_we = 1'b1; cfg_port = IW'(p); cfg_data = d;
    step();
  endtask

  task automatic send(input int src, input logic [NP-1:0] dst, input logic hit,
                      input logic ovr, input string tag);
    ev_valid = 1'b1; ev_src = IW'(src); ev_dst = dst; ev_hit = hit; ev_ovr = ovr;
    cur_tag = tag;
    do step(); while (!last_acc);
    ev_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      fails++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 50000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] states [5];
    string snames [5];
    states = '{S_DIS, S_BLK, S_LSN, S_LRN, S_FWD};
    snames = '{"disabled", "blocking", "listening", "learning", "forwarding"};
    for (int i = 0; i < NP; i++) m_cfg[i] = (i == HOST) ? S_FWD : S_DIS;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_port = '0; cfg_data = '0;
    ev_valid = 1'b0; ev_src = '0; ev_dst = '0; ev_hit = 1'b0; ev_ovr = 1'b0;
    dec_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(dec_valid == 1'b0, "R1 reset dec_valid", dec_valid, 0);
    chk(ev_ready == 1'b1, "R1 reset ev_ready", ev_ready, 1);
    @(negedge clk);
    // R1: default discarding state on all network ports
    send(0, 5'b11111, 0, 0, "R1 default state");
    send(2, 5'b10001, 0, 0, "R1 default state");

    // full state sweep on each network port
    for (int p = 0; p < HOST; p++) begin
      wr((p + 1) % HOST, S_FWD);
      wr((p + 2) % HOST, S_LRN);
      wr((p + 3) % HOST, S_DIS);
      for (int s = 0; s < 5; s++) begin
        wr(p, states[s]);
        send(p, 5'b11111, 0, 0, states[s][1] ? "R5 normal" : "R3 blocked");
        send(p, 5'b00000, 1, 1, "R4 override");
        send(p, 5'b01111, 1, 1, "R4 override");
        send(p, 5'b11111, 1, 0, states[s][1] ? "R5 hit no ovr" : "R3 hit no ovr");
        send(HOST, 5'b11111, 0, 0, "R6 host source");
        send(HOST, 5'b10000 | 5'(1 << p), 0, 0, "R6 host directed");
        send((p + 1) % HOST, 5'b11111, 0, 0, "R5 fwd peer to all");
        send((p + 1) % HOST, 5'(1 << p), 0, 0, "R5 fwd peer to swept port");
      end
    end

    // R2: writes to the host index or above are ignored
    wr(1, S_FWD);
    wr(HOST, 3'b001);
    wr(6, 3'b110);
    send(1, 5'b10000, 0, 0, "R2 host write ignored");
    send(HOST, 5'b00010, 0, 0, "R2 host write ignored");
    // R2: write in the same cycle as an event applies only to later events
    wr(0, S_FWD);
    cfg_we = 1'b1; cfg_port = 3'd0; cfg_data = S_DIS;
    send(0, 5'b11110, 0, 0, "R2 same-cycle write old value");
    send(0, 5'b11110, 0, 0, "R2 write applied next event");

    // R9: ingress index out of range
    for (int b = 5; b < 8; b++) send(b, 5'b11111, 1, 1, "R9 bad source");

    // drain
    dec_ready = 1'b1;
    for (int k = 0; k < 40 && q_mask.size() != 0; k++) step();
    chk(q_mask.size() == 0, "R10 all decisions delivered", q_mask.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule